// File: doc/BRIEF.md
# Supply Hysteresis and Fault Mode Controller

This block decides, once per clock, whether the high-voltage startup current source charges the supply capacitor, whether the gate driver may switch, and when a new soft-start ramp begins. It does not see analog levels. It sees a set of comparator flags that describe the supply voltage: at or above 12 V, at or below 10 V, below 9.8 V, below 5.3 V and below 4 V. It also sees a feedback-at-maximum overload flag, an auxiliary-winding overvoltage comparator with its sample strobe, and a thermal flag that already carries its own hysteresis.

In normal running, the supply capacitor is recharged whenever it falls to 10 V and is released at 12 V. Because nothing else times the fall from 12 V to 10 V, that discharge is used as the overload timer. If overload is held for the whole fall, switching stops and the capacitor drains to 5.3 V before a fresh start is made. An overvoltage sample latches switching off until the supply collapses below 4 V, while the capacitor keeps cycling between 5.3 V and 12 V. A thermal fault suspends switching and keeps the normal 10 V/12 V cycling. Each start at 12 V issues a one-cycle soft-start request.

Top module: `sfm_core`

## Requirements
- R1: While reset is asserted and directly after it, the mode is STARTUP, the source is enabled, switching is disabled and the soft-start pulse is low.
- R2: In STARTUP the source stays enabled until the 12 V flag is seen. The next cycle then shows mode RUN, source off, switching on and a soft-start pulse that lasts exactly one cycle.
- R3: In RUN and THERMAL_OFF the source turns off when the 12 V flag is high, turns on when the 10 V flag is high, and otherwise keeps its level.
- R4: In RUN, switching is disabled in every cycle after one in which the 9.8 V flag is high. The mode stays RUN.
- R5: A discharge starts with the first RUN cycle in which the source is off. If overload is present in every cycle from that one up to and including the cycle where the 10 V flag is seen, the mode becomes OVERLOAD_WAIT, with switching and source off. When the 5.3 V flag is seen, the mode returns to STARTUP with the source on, and the following 12 V start gives a soft-start pulse.
- R6: If overload drops for even one cycle during a discharge, reaching 10 V causes no fault. The mode stays RUN and the source turns on.
- R7: In RUN, a sample strobe with the overvoltage comparator high enters OVP_LATCH, with switching off. A strobe with the comparator low has no effect. In OVP_LATCH the source turns off at 12 V and turns on only below 5.3 V.
- R8: OVP_LATCH is left only when the 4 V flag is high, and then for STARTUP.
- R9: A thermal flag in RUN enters THERMAL_OFF with switching off. When the flag clears, the mode returns to STARTUP. A 12 V start seen in STARTUP while the flag is high enters THERMAL_OFF with no soft-start pulse.
- R10: The 4 V flag forces STARTUP from any mode. In RUN, overvoltage takes precedence over overload, and overload over the thermal flag.
- R11: The status output is one-hot: bit 0 STARTUP, bit 1 RUN, bit 2 OVERLOAD_WAIT, bit 3 OVP_LATCH, bit 4 THERMAL_OFF. All outputs are registered and follow the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_start | input | 1 | Supply at or above 12 V |
| sup_below_restart | input | 1 | Supply at or below 10 V |
| sup_below_uvlo | input | 1 | Supply below 9.8 V |
| sup_below_fault | input | 1 | Supply below 5.3 V |
| sup_below_clear | input | 1 | Supply below 4 V |
| fb_overload | input | 1 | Feedback at its maximum |
| aux_sample | input | 1 | Overvoltage sample strobe after gate turn-off |
| aux_over | input | 1 | Auxiliary-winding overvoltage comparator |
| temp_hot | input | 1 | Thermal shutdown flag, hysteresis applied |
| hv_src_en | output | 1 | High-voltage startup source enable |
| gate_en | output | 1 | Switching enable |
| softstart_go | output | 1 | One-cycle soft-start request |
| mode_status | output | 5 | One-hot mode |

## Verification
The supply is modelled as a voltage that the bench turns into the five flags. Sweeping it up and down shows that the source holds its level between thresholds and that different modes use different turn-on levels (10 V in running and thermal, 5.3 V in overvoltage latch). Overload is applied three ways: held through the whole discharge, dropped for a single cycle in mid-fall, and present together with a thermal fault. This separates a level check made only at 10 V from true continuous watching, and checks the precedence order. Strobes are sent with the comparator both low and high, and the supply is taken through 5.3 V and then below 4 V. This confirms that only the deepest collapse releases the latch.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned SFM_NMODE = 5;

  localparam int unsigned IDX_BOOT = 0;
  localparam int unsigned IDX_RUN  = 1;
  localparam int unsigned IDX_OVLD = 2;
  localparam int unsigned IDX_OVP  = 3;
  localparam int unsigned IDX_HOT  = 4;

  typedef enum logic [SFM_NMODE-1:0] {
    ST_BOOT = SFM_NMODE'(1) << IDX_BOOT,
    ST_RUN  = SFM_NMODE'(1) << IDX_RUN,
    ST_OVLD = SFM_NMODE'(1) << IDX_OVLD,
    ST_OVP  = SFM_NMODE'(1) << IDX_OVP,
    ST_HOT  = SFM_NMODE'(1) << IDX_HOT
  } sfm_mode_e;
endpackage

// File: rtl/sfm_rst_sync.sv
module sfm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sfm_src_ctrl.sv
module sfm_src_ctrl
  import sfm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sfm_mode_e mode_nxt,
  input  logic      sup_hi,
  input  logic      sup_restart,
  input  logic      sup_fault,
  output logic      src_q
);
  logic src_d;

  always_comb begin
    unique case (mode_nxt)
      ST_BOOT:        src_d = 1'b1;
      ST_RUN, ST_HOT: src_d = sup_hi ? 1'b0 : (sup_restart ? 1'b1 : src_q);
      ST_OVLD:        src_d = 1'b0;
      ST_OVP:         src_d = sup_hi ? 1'b0 : (sup_fault ? 1'b1 : src_q);
      default:        src_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b1;
    else        src_q <= src_d;
  end

  AST_SRC_OFF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_hi && mode_nxt != ST_BOOT) |=> !src_q); // R3

  AST_SRC_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_nxt == ST_RUN && !sup_hi && !sup_restart) |=> $stable(src_q)); // R3
endmodule

// File: rtl/sfm_ovl_window.sv
module sfm_ovl_window (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic src_q,
  input  logic overload,
  output logic armed_q
);
  logic src_prev_q;
  logic armed_d;
  logic discharging;

  assign discharging = in_run && !src_q;

  always_comb begin
    if (!discharging)    armed_d = 1'b0;
    else if (src_prev_q) armed_d = overload;
    else                 armed_d = armed_q && overload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev_q <= 1'b1;
      armed_q    <= 1'b0;
    end else begin
      src_prev_q <= src_q;
      armed_q    <= armed_d;
    end
  end

  AST_ARM_NEEDS_OVLD: assert property (@(posedge clk) disable iff (!rst_n)
    !overload |=> !armed_q); // R6
endmodule

// File: rtl/sfm_core.sv
module sfm_core
  import sfm_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sup_above_start,
  input  logic                 sup_below_restart,
  input  logic                 sup_below_uvlo,
  input  logic                 sup_below_fault,
  input  logic                 sup_below_clear,
  input  logic                 fb_overload,
  input  logic                 aux_sample,
  input  logic                 aux_over,
  input  logic                 temp_hot,
  output logic                 hv_src_en,
  output logic                 gate_en,
  output logic                 softstart_go,
  output logic [SFM_NMODE-1:0] mode_status
);
  logic      rst_n_s;
  sfm_mode_e state_q, state_nxt;
  logic      src_q;
  logic      armed_q;
  logic      gate_q, gate_d;
  logic      ss_q, ss_d;
  logic      ovld_trip;

  sfm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sfm_src_ctrl u_src (
    .clk(clk), .rst_n(rst_n_s), .mode_nxt(state_nxt),
    .sup_hi(sup_above_start), .sup_restart(sup_below_restart),
    .sup_fault(sup_below_fault), .src_q(src_q)
  );

  sfm_ovl_window u_win (
    .clk(clk), .rst_n(rst_n_s), .in_run(state_q == ST_RUN),
    .src_q(src_q), .overload(fb_overload), .armed_q(armed_q)
  );

  assign ovld_trip = !src_q && sup_below_restart && armed_q && fb_overload;

  always_comb begin
    state_nxt = state_q;
    if (sup_below_clear) begin
      state_nxt = ST_BOOT;
    end else begin
      unique case (state_q)
        ST_BOOT: if (sup_above_start) state_nxt = temp_hot ? ST_HOT : ST_RUN;
        ST_RUN: begin
          if (aux_sample && aux_over) state_nxt = ST_OVP;
          else if (ovld_trip)         state_nxt = ST_OVLD;
          else if (temp_hot)          state_nxt = ST_HOT;
        end
        ST_OVLD: if (sup_below_fault) state_nxt = ST_BOOT;
        ST_OVP:  state_nxt = ST_OVP;
        ST_HOT:  if (!temp_hot) state_nxt = ST_BOOT;
        default: state_nxt = ST_BOOT;
      endcase
    end
  end

  assign gate_d = (state_nxt == ST_RUN) && !sup_below_uvlo;
  assign ss_d   = (state_q == ST_BOOT) && (state_nxt == ST_RUN);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_BOOT;
      gate_q  <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      gate_q  <= gate_d;
      ss_q    <= ss_d;
    end
  end

  assign hv_src_en    = src_q;
  assign gate_en      = gate_q;
  assign softstart_go = ss_q;
  assign mode_status  = state_q;

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot(state_q)); // R11

  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    softstart_go |=> !softstart_go); // R2

  AST_OVP_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_OVP && !sup_below_clear) |=> state_q == ST_OVP); // R8

  AST_OVLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(state_q[IDX_OVLD]) |-> $past(fb_overload)); // R5

  AST_UVLO_GATE: assert property (@(posedge clk) disable iff (!rst_n_s)
    sup_below_uvlo |=> !gate_en); // R4
endmodule

// File: tb/sim_sfm_core.sv
`timescale 1ns/1ps
module sim_sfm_core;
  logic clk = 1'b0;
  logic rst_n;
  logic hi, le_on, uv, flt, por, ovld, smp, ovr, hot;
  logic src, gate, ss;
  logic [4:0] st;
  int checks = 0;
  int fails  = 0;

  localparam logic [4:0] M_BOOT = 5'b00001, M_RUN = 5'b00010, M_OVLD = 5'b00100,
                         M_OVP = 5'b01000, M_HOT = 5'b10000;

  always #4 clk = ~clk;

  sfm_core u0 (
    .clk(clk), .rst_n(rst_n), .sup_above_start(hi), .sup_below_restart(le_on),
    .sup_below_uvlo(uv), .sup_below_fault(flt), .sup_below_clear(por),
    .fb_overload(ovld), .aux_sample(smp), .aux_over(ovr), .temp_hot(hot),
    .hv_src_en(src), .gate_en(gate), .softstart_go(ss), .mode_status(st)
  );

  task automatic vcc(input int mv);
    hi = (mv >= 12000); le_on = (mv <= 10000); uv = (mv < 9800);
    flt = (mv < 5300); por = (mv < 4000);
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vcc(0); ovld = 0; smp = 0; ovr = 0; hot = 0;
    cyc(3);
    chk("R1", "mode in reset", st, M_BOOT);
    chk("R1", "src in reset", src, 1);
    chk("R1", "gate in reset", gate, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1", "mode after reset", st, M_BOOT);
    chk("R1", "soft-start after reset", ss, 0);
    chk("R11", "status one-hot boot", st, 5'b00001);
  endtask

  task automatic t_start();
    vcc(11000); cyc();
    chk("R2", "below 12V stays boot", st, M_BOOT);
    chk("R2", "src on while charging", src, 1);
    vcc(12000); cyc();
    chk("R2", "mode run", st, M_RUN);
    chk("R2", "src off at 12V", src, 0);
    chk("R2", "gate on", gate, 1);
    chk("R2", "soft-start pulse", ss, 1);
    cyc();
    chk("R2", "soft-start one cycle", ss, 0);
  endtask

  task automatic t_hyst();
    vcc(11000); cyc();
    chk("R3", "hold off in band", src, 0);
    vcc(10000); cyc();
    chk("R3", "on at 10V", src, 1);
    chk("R3", "gate kept at 10V", gate, 1);
    vcc(11000); cyc();
    chk("R3", "hold on in band", src, 1);
    vcc(12000); cyc();
    chk("R3", "off at 12V", src, 0);
  endtask

  task automatic t_uv();
    vcc(9700); cyc();
    chk("R4", "gate off under uvlo", gate, 0);
    chk("R4", "mode stays run", st, M_RUN);
    vcc(10000); cyc();
    chk("R4", "gate back on", gate, 1);
  endtask

  task automatic t_ovl_glitch();
    vcc(10000); cyc();
    ovld = 1; vcc(12000); cyc();
    vcc(11000); cyc();
    ovld = 0; cyc();
    ovld = 1; cyc();
    vcc(10000); cyc();
    chk("R6", "no fault after overload gap", st, M_RUN);
    chk("R6", "src on at 10V", src, 1);
    ovld = 0; cyc();
  endtask

  task automatic t_ovl();
    vcc(10000); cyc();
    ovld = 1; vcc(12000); cyc();
    vcc(11000); cyc(2);
    vcc(10000); cyc();
    chk("R5", "overload wait", st, M_OVLD);
    chk("R5", "gate off", gate, 0);
    chk("R5", "src off", src, 0);
    vcc(7000); cyc(2);
    chk("R5", "still waiting", st, M_OVLD);
    chk("R5", "src still off", src, 0);
    vcc(5200); cyc();
    chk("R5", "restart boot", st, M_BOOT);
    chk("R5", "src on at 5.3V", src, 1);
    ovld = 0; vcc(12000); cyc();
    chk("R5", "new start", st, M_RUN);
    chk("R5", "soft-start on restart", ss, 1);
  endtask

  task automatic t_ovp();
    cyc();
    smp = 1; ovr = 0; cyc();
    chk("R7", "strobe without overvoltage ignored", st, M_RUN);
    chk("R7", "gate kept", gate, 1);
    ovr = 1; cyc();
    smp = 0; ovr = 0;
    chk("R7", "latched", st, M_OVP);
    chk("R7", "gate off", gate, 0);
    vcc(10000); cyc();
    chk("R7", "no recharge at 10V", src, 0);
    vcc(5200); cyc();
    chk("R7", "recharge below 5.3V", src, 1);
    vcc(9000); cyc();
    chk("R7", "hold on", src, 1);
    vcc(12000); cyc();
    chk("R7", "off at 12V", src, 0);
    chk("R8", "still latched after cycling", st, M_OVP);
    vcc(5000); cyc();
    chk("R8", "5V does not clear", st, M_OVP);
    vcc(3900); cyc();
    chk("R8", "cleared below 4V", st, M_BOOT);
    chk("R8", "src on after clear", src, 1);
  endtask

  task automatic t_thermal();
    vcc(12000); cyc();
    chk("R9", "run before heat", st, M_RUN);
    hot = 1; cyc();
    chk("R9", "thermal off", st, M_HOT);
    chk("R9", "gate off", gate, 0);
    vcc(10000); cyc();
    chk("R9", "src on at 10V in thermal", src, 1);
    vcc(12000); cyc();
    chk("R9", "src off at 12V in thermal", src, 0);
    hot = 0; cyc();
    chk("R9", "cool returns boot", st, M_BOOT);
    cyc();
    chk("R9", "restart after cool", ss, 1);
    vcc(3000); cyc();
    chk("R10", "collapse from run", st, M_BOOT);
    hot = 1; vcc(11000); cyc();
    vcc(12000); cyc();
    chk("R9", "hot at start", st, M_HOT);
    chk("R9", "no soft-start when hot", ss, 0);
    hot = 0; cyc(2);
    chk("R9", "run after cool", st, M_RUN);
  endtask

  task automatic t_prio();
    vcc(10000); cyc();
    ovld = 1; vcc(12000); cyc();
    vcc(11000); cyc();
    hot = 1; vcc(10000); cyc();
    chk("R10", "overload beats thermal", st, M_OVLD);
    hot = 0; ovld = 0; vcc(5000); cyc();
    vcc(12000); cyc();
    hot = 1; smp = 1; ovr = 1; cyc();
    hot = 0; smp = 0; ovr = 0;
    chk("R10", "overvoltage beats thermal", st, M_OVP);
    vcc(3000); cyc();
    chk("R10", "collapse clears latch", st, M_BOOT);
    chk("R11", "status boot code", st, 5'b00001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_hyst();
    t_uv();
    t_ovl_glitch();
    t_ovl();
    t_ovp();
    t_thermal();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule